// File: doc/BRIEF.md
# Reference Frequency Selection Network

This block derives the comparison references for two phase detectors, one serving a receive synthesizer loop and one serving a transmit loop, from a single oscillator clock. A main programmable counter divides the oscillator by a 12-bit ratio. Two fixed prescalers follow it and produce the main rate divided by 4 and by 25. An auxiliary programmable counter with a 14-bit ratio runs independently beside them. Each detector has its own 2-bit select that picks one of the four candidates. When a counter is switched off, a fixed substitution takes its place.

All references are single-cycle strobes in the oscillator clock domain. The strobe marks the falling edge that the detector compares against. Each ratio register is sampled only when its counter reaches terminal count, so a rewrite never produces a short interval. The block also provides a scaled clock for an attached microcontroller, running at the oscillator rate divided by 4 or by 3.

Top module: `refclk_route`

## Requirements
- R1: With the main counter enabled and a ratio N from 13 to 4095, the main candidate (select code 0) strobes once every N oscillator cycles.
- R2: A main or auxiliary ratio below 13 (including 0) is treated as 13.
- R3: Select code 1 yields one strobe every 4·N cycles and select code 2 one strobe every 25·N cycles, where N is the main ratio.
- R4: Select code 3 yields the auxiliary candidate: one strobe every M cycles for an auxiliary ratio M from 13 to 16383.
- R5: The receive select (rx_sel_i) and the transmit select (tx_sel_i) use the same encoding and act independently, so the two outputs may carry different candidates at the same time.
- R6: While the main counter is disabled (main_en_i = 0), both outputs carry the auxiliary candidate whatever their selects, and strobe in the same cycles.
- R7: While the auxiliary counter is disabled (aux_en_i = 0), select code 3 delivers the main/25 candidate. With both counters disabled, neither output strobes.
- R8: mcu_clk_o has a period of 4 oscillator cycles when mcu_fast_i = 0 and 3 cycles when mcu_fast_i = 1, and is never high for more than 2 consecutive cycles.
- R9: A new ratio takes effect at the next terminal count. If it is written in the cycle that ends at terminal count, the next interval uses it. If it is written one cycle later, the interval then in progress keeps the old length.
- R10: While rst_ni is low, rx_ref_o, tx_ref_o and mcu_clk_o are 0.
- R11: Every strobe on rx_ref_o and tx_ref_o lasts exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| main_en_i | input | 1 | Main reference counter enable |
| aux_en_i | input | 1 | Auxiliary counter enable |
| main_ratio_i | input | 12 | Main division ratio |
| aux_ratio_i | input | 14 | Auxiliary division ratio |
| rx_sel_i | input | 2 | Receive reference select (0 main, 1 main/4, 2 main/25, 3 auxiliary) |
| tx_sel_i | input | 2 | Transmit reference select, same encoding |
| mcu_fast_i | input | 1 | Microcontroller clock divide: 0 by 4, 1 by 3 |
| rx_ref_o | output | 1 | Receive detector reference strobe |
| tx_ref_o | output | 1 | Transmit detector reference strobe |
| mcu_clk_o | output | 1 | Scaled microcontroller clock |

## Verification
The critical coincidence is a ratio rewrite landing in the same cycle as the counter's terminal count, where the reload and the wrap happen together. The bench aligns to an observed strobe and then applies the new ratio exactly one cycle before the next terminal edge. It requires the following interval to already have the new length. It then repeats the rewrite one cycle later and requires the old length to persist for one more interval. A second coincidence is both detector outputs strobing in one cycle when the main counter is off. Both are checked at every cycle of a window.

// File: rtl/refnet_pkg.sv
package refnet_pkg;

  typedef enum logic [1:0] {
    SRC_FULL  = 2'd0,
    SRC_QUART = 2'd1,
    SRC_FINE  = 2'd2,
    SRC_AUX   = 2'd3
  } ref_src_e;

  localparam int unsigned NUM_DET = 2;

  function automatic logic pick_src(input logic [1:0] sel, input logic full,
                                    input logic quart, input logic fine, input logic aux);
    unique case (ref_src_e'(sel))
      SRC_FULL:  pick_src = full;
      SRC_QUART: pick_src = quart;
      SRC_FINE:  pick_src = fine;
      default:   pick_src = aux;
    endcase
  endfunction

endpackage

// File: rtl/ratio_div.sv
module ratio_div #(
  parameter int unsigned W   = 12,
  parameter int unsigned MIN = 13
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] ratio_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q, per_q, ratio_c;

  assign ratio_c = (ratio_i < W'(MIN)) ? W'(MIN) : ratio_i;

  // period register reloads only at wrap or while idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      per_q  <= W'(MIN);
      tick_o <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      per_q  <= ratio_c;
      tick_o <= 1'b0;
    end else if (cnt_q == per_q - W'(1)) begin
      cnt_q  <= '0;
      per_q  <= ratio_c;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + W'(1);
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/tick_prescale.sv
module tick_prescale #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  output logic strobe_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;

  assign strobe_o = en_i && tick_i && (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (!en_i)               cnt_q <= '0;
    else if (tick_i && strobe_o)  cnt_q <= '0;
    else if (tick_i)              cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/mcu_clk_gen.sv
module mcu_clk_gen #(
  parameter int unsigned SLOW = 4,
  parameter int unsigned FAST = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fast_i,
  output logic clk_o
);
  localparam int unsigned CW = $clog2(SLOW);

  logic [CW-1:0] cnt_q, cnt_nxt, lim, half;

  assign lim     = fast_i ? CW'(FAST) : CW'(SLOW - 1) + CW'(1);
  assign half    = fast_i ? CW'(FAST / 2) : CW'(SLOW / 2);
  assign cnt_nxt = (cnt_q >= lim - CW'(1)) ? '0 : cnt_q + CW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      clk_o <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      clk_o <= (cnt_nxt < half);
    end
  end
endmodule

// File: rtl/refclk_route.sv
module refclk_route
  import refnet_pkg::*;
#(
  parameter int unsigned MAIN_W     = 12,
  parameter int unsigned AUX_W      = 14,
  parameter int unsigned MIN_RATIO  = 13,
  parameter int unsigned COARSE_DIV = 4,
  parameter int unsigned FINE_DIV   = 25,
  parameter int unsigned MCU_SLOW   = 4,
  parameter int unsigned MCU_FAST   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              main_en_i,
  input  logic              aux_en_i,
  input  logic [MAIN_W-1:0] main_ratio_i,
  input  logic [AUX_W-1:0]  aux_ratio_i,
  input  logic [1:0]        rx_sel_i,
  input  logic [1:0]        tx_sel_i,
  input  logic              mcu_fast_i,
  output logic              rx_ref_o,
  output logic              tx_ref_o,
  output logic              mcu_clk_o
);
  logic main_tick, aux_tick, quart_tick, fine_tick, aux_eff;
  logic [1:0]         sel_arr [NUM_DET];
  logic [NUM_DET-1:0] pick, det_q;

  ratio_div #(.W(MAIN_W), .MIN(MIN_RATIO)) i_main (
    .clk_i, .rst_ni, .en_i(main_en_i), .ratio_i(main_ratio_i), .tick_o(main_tick)
  );

  ratio_div #(.W(AUX_W), .MIN(MIN_RATIO)) i_aux (
    .clk_i, .rst_ni, .en_i(aux_en_i), .ratio_i(aux_ratio_i), .tick_o(aux_tick)
  );

  tick_prescale #(.DIV(COARSE_DIV)) i_quart (
    .clk_i, .rst_ni, .en_i(main_en_i), .tick_i(main_tick), .strobe_o(quart_tick)
  );

  tick_prescale #(.DIV(FINE_DIV)) i_fine (
    .clk_i, .rst_ni, .en_i(main_en_i), .tick_i(main_tick), .strobe_o(fine_tick)
  );

  // idle auxiliary counter falls back to main/25
  assign aux_eff = aux_en_i ? aux_tick : fine_tick;

  assign sel_arr[0] = rx_sel_i;
  assign sel_arr[1] = tx_sel_i;

  for (genvar g = 0; g < NUM_DET; g++) begin : g_det
    assign pick[g] = main_en_i ?
        pick_src(sel_arr[g], main_tick & main_en_i, quart_tick, fine_tick, aux_eff) : aux_eff;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) det_q <= '0;
    else         det_q <= pick;
  end

  assign rx_ref_o = det_q[0];
  assign tx_ref_o = det_q[1];

  mcu_clk_gen #(.SLOW(MCU_SLOW), .FAST(MCU_FAST)) i_mcu (
    .clk_i, .rst_ni, .fast_i(mcu_fast_i), .clk_o(mcu_clk_o)
  );
endmodule

// File: rtl/refclk_route_chk.sv
module refclk_route_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic main_en_i,
  input logic aux_en_i,
  input logic rx_ref_o,
  input logic tx_ref_o,
  input logic mcu_clk_o,
  input logic aux_tick_i
);
  AST_RX_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ref_o |=> !rx_ref_o); // R11
  AST_TX_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ref_o |=> !tx_ref_o); // R11
  AST_MAIN_OFF_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!main_en_i) |-> (rx_ref_o == tx_ref_o)); // R6
  AST_ALL_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!main_en_i && !aux_en_i) |-> (!rx_ref_o && !tx_ref_o)); // R7
  AST_AUX_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!aux_en_i) |-> !aux_tick_i); // R7
  AST_MCU_DUTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mcu_clk_o && $past(mcu_clk_o)) |=> !mcu_clk_o); // R8
endmodule

bind refclk_route refclk_route_chk i_refclk_route_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .main_en_i  (main_en_i),
  .aux_en_i   (aux_en_i),
  .rx_ref_o   (rx_ref_o),
  .tx_ref_o   (tx_ref_o),
  .mcu_clk_o  (mcu_clk_o),
  .aux_tick_i (aux_tick)
);

// File: tb/test_refclk_route.sv
module test_refclk_route;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        main_en = 1'b0, aux_en = 1'b0, mcu_fast = 1'b0;
  logic [11:0] main_ratio = 12'd20;
  logic [13:0] aux_ratio = 14'd37;
  logic [1:0]  rx_sel = 2'd0, tx_sel = 2'd0;
  logic        rx_ref, tx_ref, mcu_clk;
  int checks = 0, errors = 0;
  localparam int LIMIT = 20000;

  always #4ns clk = ~clk;

  refclk_route i_refclk_route (
    .clk_i(clk), .rst_ni(rst_n), .main_en_i(main_en), .aux_en_i(aux_en),
    .main_ratio_i(main_ratio), .aux_ratio_i(aux_ratio), .rx_sel_i(rx_sel),
    .tx_sel_i(tx_sel), .mcu_fast_i(mcu_fast), .rx_ref_o(rx_ref),
    .tx_ref_o(tx_ref), .mcu_clk_o(mcu_clk)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic smp(input int src);
    case (src)
      0:       smp = rx_ref;
      1:       smp = tx_ref;
      default: smp = mcu_clk;
    endcase
  endfunction

  // cycles until next strobe (src 0/1) or rising edge (src 2)
  task automatic wait_ev(input int src, output int t);
    logic prev, cur, hit;
    prev = smp(src);
    t = 0;
    do begin
      @(negedge clk);
      t++;
      cur = smp(src);
      hit = (src == 2) ? (cur && !prev) : cur;
      prev = cur;
    end while (!hit && t < LIMIT);
    if (!hit) t = -1;
  endtask

  task automatic measure(input int src, output int per);
    int t;
    wait_ev(src, t);
    wait_ev(src, t);
    wait_ev(src, t);
    per = t;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R10 rx_ref in reset", rx_ref, 0);
    chk("R10 tx_ref in reset", tx_ref, 0);
    chk("R10 mcu_clk in reset", mcu_clk, 0);
    rst_n = 1'b1;
    main_en = 1'b1;
    aux_en = 1'b1;
  endtask

  task automatic t_main_div;
    int p;
    rx_sel = 2'd0; tx_sel = 2'd0; main_ratio = 12'd20;
    measure(0, p); chk("R1 main ratio 20", p, 20);
    main_ratio = 12'd4095;
    measure(0, p); chk("R1 main ratio 4095", p, 4095);
    main_ratio = 12'd13;
    measure(1, p); chk("R1 main ratio 13 on tx", p, 13);
  endtask

  task automatic t_clamp;
    int p;
    main_ratio = 12'd5;
    measure(0, p); chk("R2 ratio 5 clamps", p, 13);
    main_ratio = 12'd0;
    measure(0, p); chk("R2 ratio 0 clamps", p, 13);
    aux_ratio = 14'd2; rx_sel = 2'd3;
    measure(0, p); chk("R2 aux ratio 2 clamps", p, 13);
    aux_ratio = 14'd37; rx_sel = 2'd0;
  endtask

  task automatic t_post;
    int p;
    main_ratio = 12'd20; rx_sel = 2'd1; tx_sel = 2'd2;
    measure(0, p); chk("R3 code 1 gives x4", p, 80);
    measure(1, p); chk("R3 R5 code 2 on tx gives x25", p, 500);
  endtask

  task automatic t_aux;
    int p;
    rx_sel = 2'd3; tx_sel = 2'd0;
    measure(0, p); chk("R4 auxiliary ratio 37", p, 37);
    measure(1, p); chk("R5 tx keeps main while rx on aux", p, 20);
  endtask

  task automatic t_main_off;
    int p, mism;
    main_en = 1'b0; rx_sel = 2'd0; tx_sel = 2'd2;
    measure(0, p); chk("R6 rx follows aux", p, 37);
    measure(1, p); chk("R6 tx follows aux", p, 37);
    mism = 0;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      if (rx_ref != tx_ref) mism++;
    end
    chk("R6 rx and tx strobe together", mism, 0);
    main_en = 1'b1;
  endtask

  task automatic t_aux_off;
    int p, n;
    aux_en = 1'b0; rx_sel = 2'd3; tx_sel = 2'd0; main_ratio = 12'd20;
    measure(0, p); chk("R7 aux off gives main/25", p, 500);
    main_en = 1'b0;
    n = 0;
    for (int i = 0; i < 700; i++) begin
      @(negedge clk);
      if (rx_ref || tx_ref) n++;
    end
    chk("R7 both counters off, no strobes", n, 0);
    main_en = 1'b1; aux_en = 1'b1;
  endtask

  task automatic t_update;
    int t, p;
    rx_sel = 2'd0; main_ratio = 12'd20;
    measure(0, p);
    wait_ev(0, t);
    repeat (18) @(negedge clk);
    main_ratio = 12'd30;
    wait_ev(0, t); chk("R9 interval before on-time rewrite", 18 + t, 20);
    wait_ev(0, t); chk("R9 rewrite at terminal count applies", t, 30);
    repeat (29) @(negedge clk);
    main_ratio = 12'd20;
    wait_ev(0, t); chk("R9 interval before late rewrite", 29 + t, 30);
    wait_ev(0, t); chk("R9 late rewrite keeps old length", t, 30);
    wait_ev(0, t); chk("R9 late rewrite applies next", t, 20);
  endtask

  task automatic t_pulse;
    int dbl, n;
    logic pr, pt;
    main_ratio = 12'd13; rx_sel = 2'd0; tx_sel = 2'd3;
    dbl = 0; n = 0; pr = 1'b0; pt = 1'b0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if ((rx_ref && pr) || (tx_ref && pt)) dbl++;
      if (rx_ref) n++;
      pr = rx_ref; pt = tx_ref;
    end
    chk("R11 no strobe longer than one cycle", dbl, 0);
    chk("R11 strobes present in window", int'(n > 0), 1);
  endtask

  task automatic t_mcu;
    int p;
    mcu_fast = 1'b0;
    measure(2, p); chk("R8 mcu divide by 4", p, 4);
    mcu_fast = 1'b1;
    measure(2, p); chk("R8 mcu divide by 3", p, 3);
  endtask

  initial begin
    t_reset();
    t_main_div();
    t_clamp();
    t_post();
    t_aux();
    t_main_off();
    t_aux_off();
    t_update();
    t_pulse();
    t_mcu();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule